// File: doc/BRIEF.md
# Multiplexed-Bus Burst Memory Slave

This block lets an external processor reach an on-chip memory over a bus that carries both addresses and data on the same wires. The processor raises an address strobe to present a start address. It then issues a run of active-low read or write pulses, and each pulse moves one word to or from the next memory location. The memory itself is a plain behavioural array inside the block.

Only one free-running system clock is used. The address strobe, the read strobe, the write strobe and the shared bus are all sampled as ordinary inputs through a two-stage synchroniser, and edges are found by comparing each synchronised value with its previous sample. A load-pending flag is set at the end of an address phase. At the next data strobe it decides whether the counter takes the newly latched start address or simply keeps counting. The system clock must run at least about three times the bus transfer rate, so that every strobe phase is sampled at least twice.

Top module: `mux_burst_slave`

## Requirements
- R1: When the address strobe falls, the low AW bits of the bus value sampled during the address phase become the start address, and the first data strobe after it accesses that location.
- R2: Each low pulse of the write strobe stores the bus word sampled while the strobe is low. Successive pulses fill successive locations.
- R3: While the read strobe is low, the block drives the bus with the word at the current address. When the read strobe is high, the block releases the bus.
- R4: The address advances by one after every read or write strobe rises, so reads and writes mixed in one burst use consecutive locations.
- R5: The address wraps from DEPTH-1 to 0.
- R6: An address phase only arms a reload, which happens at the next data strobe. If several address phases come with no strobe between them, the last one wins. An address phase in the middle of a burst restarts the burst at the new address.
- R7: Overlapping activity is ignored. This covers the address strobe together with a data strobe, and the read strobe together with the write strobe. Overlap writes no memory and does not move the address.
- R8: After reset the address counter is 0 and no reload is armed, so a burst with no address phase starts at location 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address strobe, active high, address valid on the bus while high |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| ad_io | inout | DW | Shared address/data bus |

## Verification
Any strobe edge on the pins shows up at the edge detector after the second clock edge. The block acts on it at the third edge: it writes memory, loads or advances the address, or arms the reload. For a read, the word is registered one edge after the address update, so it is on the bus by the fourth edge after the read strobe falls. The bench holds every strobe phase for at least four clocks and samples read data at the sixth falling edge. Expected memory contents come from an arithmetic pattern kept in the bench, and this covers a full sweep of all locations, wrapping bursts, mixed bursts, reloads and overlap cases.

// File: rtl/mux_burst_slave.sv
module mux_burst_slave #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  inout  wire  [DW-1:0] ad_io
);
  localparam int DEPTH = 1 << AW;

  logic [2:0] ale_sh, rd_sh, wr_sh;
  logic [DW-1:0] bus1, bus2, bus_q;
  logic [AW-1:0] addr, base;
  logic pend;
  logic [DW-1:0] rdata;
  logic [DW-1:0] mem [DEPTH];

  wire ale_s = ale_sh[1];
  wire ale_q = ale_sh[2];
  wire rd_s  = rd_sh[1];
  wire rd_q  = rd_sh[2];
  wire wr_s  = wr_sh[1];
  wire wr_q  = wr_sh[2];

  wire ov_now  = (ale_s & ~rd_s) | (ale_s & ~wr_s) | (~rd_s & ~wr_s);
  wire ov_prev = (ale_q & ~rd_q) | (ale_q & ~wr_q) | (~rd_q & ~wr_q);
  wire illegal = ov_now | ov_prev;

  wire ale_fall = ale_q & ~ale_s & ~illegal;
  wire acc_fall = ((rd_q & ~rd_s) | (wr_q & ~wr_s)) & ~illegal;
  wire wr_rise  = ~wr_q & wr_s & ~illegal;
  wire acc_rise = ((~rd_q & rd_s) | (~wr_q & wr_s)) & ~illegal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_sh <= 3'b000;
      rd_sh  <= 3'b111;
      wr_sh  <= 3'b111;
      bus1   <= '0;
      bus2   <= '0;
      bus_q  <= '0;
    end else begin
      ale_sh <= {ale_sh[1:0], ale_i};
      rd_sh  <= {rd_sh[1:0], rd_n_i};
      wr_sh  <= {wr_sh[1:0], wr_n_i};
      bus1   <= ad_io;
      bus2   <= bus1;
      bus_q  <= bus2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      base <= '0;
      pend <= 1'b0;
    end else begin
      if (ale_fall) begin
        base <= bus_q[AW-1:0];
        pend <= 1'b1;
      end else if (acc_fall) begin
        pend <= 1'b0;
        if (pend) addr <= base;
      end else if (acc_rise) begin
        addr <= addr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_rise) mem[addr] <= bus_q;
    rdata <= mem[addr];
  end

  assign ad_io = rd_n_i ? {DW{1'bz}} : rdata;
endmodule

module mux_burst_slave_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ale_fall,
  input logic          acc_fall,
  input logic          acc_rise,
  input logic          illegal,
  input logic          pend,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] base
);
  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rise && !acc_fall && !ale_fall) |=> (addr == AW'($past(addr) + 1'b1)));

  // R6
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_fall |=> pend);

  // R6
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fall && !ale_fall) |=> !pend);

  // R1
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fall && !ale_fall && pend) |=> (addr == $past(base)));

  // R7
  ovl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(addr));
endmodule

bind mux_burst_slave mux_burst_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale_fall(ale_fall), .acc_fall(acc_fall),
  .acc_rise(acc_rise), .illegal(illegal), .pend(pend), .addr(addr), .base(base)
);

// File: tb/mux_burst_slave_bench.sv
`timescale 1ns/1ps
module mux_burst_slave_bench;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic tb_oe = 1'b0;
  logic [DW-1:0] tb_dat = '0;
  wire  [DW-1:0] ad;
  logic [DW-1:0] exp_mem [DEPTH];
  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] got;

  assign ad = tb_oe ? tb_dat : {DW{1'bz}};

  always #2 clk = ~clk;

  mux_burst_slave #(.DW(DW), .AW(AW)) u_mux_burst_slave (
    .clk(clk), .rst_n(rst_n), .ale_i(ale), .rd_n_i(rd_n), .wr_n_i(wr_n), .ad_io(ad)
  );

  function automatic logic [DW-1:0] pat(int a, int k);
    return DW'(a * 37 + k * 11 + 5);
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic addr_phase(int a);
    tb_oe = 1'b1; tb_dat = DW'(a); wait_n(1);
    ale = 1'b1; wait_n(4);
    ale = 1'b0; wait_n(3);
    tb_oe = 1'b0; wait_n(1);
  endtask

  task automatic wr_word(logic [DW-1:0] d);
    tb_oe = 1'b1; tb_dat = d; wait_n(1);
    wr_n = 1'b0; wait_n(5);
    wr_n = 1'b1; wait_n(3);
    tb_oe = 1'b0;
  endtask

  task automatic rd_word(output logic [DW-1:0] d);
    tb_oe = 1'b0; wait_n(1);
    rd_n = 1'b0; wait_n(6);
    d = ad;
    rd_n = 1'b1; wait_n(4);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(3);

    // R8: burst with no address phase starts at 0
    wr_word(pat(0, 0)); exp_mem[0] = pat(0, 0);
    wr_word(pat(1, 0)); exp_mem[1] = pat(1, 0);

    // R1 R2: fill 2..15
    addr_phase(2);
    for (int a = 2; a < DEPTH; a++) begin
      wr_word(pat(a, 0)); exp_mem[a] = pat(a, 0);
    end

    // R3 R8: sweep read all locations
    addr_phase(0);
    for (int a = 0; a < DEPTH; a++) begin
      rd_word(got);
      check(a < 2 ? "R8" : "R2/R3", got, exp_mem[a]);
    end

    // R5: wrapping write and read bursts from every start near the top
    for (int s = DEPTH - 3; s < DEPTH; s++) begin
      addr_phase(s);
      for (int k = 0; k < 4; k++) begin
        wr_word(pat(s + k, s)); exp_mem[(s + k) % DEPTH] = pat(s + k, s);
      end
      addr_phase(s);
      for (int k = 0; k < 4; k++) begin
        rd_word(got); check("R5", got, exp_mem[(s + k) % DEPTH]);
      end
    end

    // R4: mixed read/write in one burst
    addr_phase(6);
    rd_word(got); check("R4", got, exp_mem[6]);
    wr_word(8'hA7); exp_mem[7] = 8'hA7;
    rd_word(got); check("R4", got, exp_mem[8]);
    addr_phase(7);
    rd_word(got); check("R4", got, 8'hA7);

    // R6: last address phase wins, mid-burst restart
    addr_phase(3);
    addr_phase(9);
    rd_word(got); check("R6", got, exp_mem[9]);
    addr_phase(4);
    rd_word(got); check("R6", got, exp_mem[4]);
    rd_word(got); check("R6", got, exp_mem[5]);
    addr_phase(11);
    rd_word(got); check("R6", got, exp_mem[11]);

    // R7: write during address phase is ignored
    tb_oe = 1'b1; tb_dat = 8'd5; wait_n(1);
    ale = 1'b1; wait_n(3);
    tb_dat = 8'hEE; wait_n(1);
    wr_n = 1'b0; wait_n(4);
    wr_n = 1'b1; wait_n(3);
    tb_dat = 8'd5; wait_n(4);
    ale = 1'b0; wait_n(3);
    tb_oe = 1'b0; wait_n(1);
    rd_word(got); check("R7", got, exp_mem[5]);
    rd_word(got); check("R7", got, exp_mem[6]);

    // R7: read and write together are ignored
    addr_phase(10);
    rd_n = 1'b0; wr_n = 1'b0; wait_n(5);
    rd_n = 1'b1; wr_n = 1'b1; wait_n(4);
    rd_word(got); check("R7", got, exp_mem[10]);
    rd_word(got); check("R7", got, exp_mem[11]);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule